// File: doc/BRIEF.md
# Condition Report Frame Writer

This block answers one condition query from a peripheral port. A query gives the port number, the address of a receive buffer and the condition mask that the requester read from its command list. The block decodes the mask, picks the pad or the keyboard function, takes one entry from that function's input queue and writes a four-word data-transfer frame into the receive buffer through a 32-bit memory write port. When all four writes have been accepted it pulses `done`.

The frame has a fixed shape: a header that identifies the responder and the frame length, the function code of the device being reported, then an eight-byte payload. Pad buttons go out active low. An empty pad queue reports every button released, and an empty keyboard queue reports no key. A mask that names neither supported function writes nothing; the block answers with `done` and `unsupported` together.

The block is a leaf under a list walker that owns the queues and the command parsing. It takes a new query only while it is idle.

Top module: `crf_writer`

## Requirements
- R1: `req_ready` is high exactly when no frame is being written or finished. A query is taken on a cycle with `req_valid` and `req_ready` both high, and `req_valid` has no effect while `req_ready` is low.
- R2: The word at receive address +0 is {response code (default 0x08), (port<<6)|0x20, port<<6, 0x03}, from bit 31 down to bit 0.
- R3: The condition mask is `req_cond` with its byte lanes reversed (bus bits 7:0 form mask bits 31:24). The pad function is mask bit 24 and the keyboard function is mask bit 30, so on the bus these are 0x00000001 and 0x00000040. The word at +4 is the chosen function's one-hot code in that same lane-reversed form.
- R4: When both function bits are set, the pad report is produced.
- R5: Pad report: the word at +8 is {16'h0000, ~button word}, so button byte 0 sits in bits 7:0. The word at +12 is zero. An empty pad queue gives 0x0000FFFF.
- R6: Keyboard report: the word at +8 is {8'h00, scan code, 8'h00 LED state, modifier}. The word at +12 is zero. An empty keyboard queue gives 0x00000000.
- R7: On the accepting cycle, exactly the chosen queue's pop strobe is high, and only if that queue is not empty. No pop happens on any other cycle.
- R8: Words go out in the order +0, +4, +8, +12. `wr_valid`, `wr_addr` and `wr_data` hold steady until `wr_ready` takes the word.
- R9: `done` is a one-cycle pulse in the cycle after the fourth accepted write, and each frame makes exactly four writes.
- R10: A mask with neither function bit set makes no write and no pop. `done` and `unsupported` rise together in the cycle after acceptance. `unsupported` is never high without `done`.
- R11: While reset is held, `req_ready` is 1 and `wr_valid`, `done` and `unsupported` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Query present |
| req_ready | output | 1 | Block idle, query can be taken |
| req_port | input | PORT_W | Responding port number |
| req_addr | input | ADDR_W | Receive buffer byte address |
| req_cond | input | 32 | Condition mask as read from memory |
| pad_empty | input | 1 | Pad queue has no entry |
| pad_btn | input | BTN_W | Head of pad queue, buttons active high |
| pad_pop | output | 1 | Remove head of pad queue |
| kbd_empty | input | 1 | Keyboard queue has no entry |
| kbd_mod | input | 8 | Head entry modifier byte |
| kbd_code | input | 8 | Head entry scan code |
| kbd_pop | output | 1 | Remove head of keyboard queue |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write data |
| done | output | 1 | Query finished (pulse) |
| unsupported | output | 1 | Query named no supported function (with done) |

## Verification
On every cycle the assertions check the write handshake: the held address and data, the +4 address step and the frame length byte. They also check that pops only happen on an accepted query with a non-empty queue and that at most one queue is popped. They check the one-cycle `done` pulse and that there are four writes before a normal `done` and none before an unsupported one. Only the bench scenarios can show the frame contents: the port fields in the header, the lane-reversed function code, the inverted buttons, the keyboard byte layout, the pad-over-keyboard priority and the empty-queue values. The bench compares these against its reference on every clock, under both steady and irregular `wr_ready`.

// File: rtl/crf_pkg.sv
package crf_pkg;

   typedef enum logic [1:0] {
      CRF_IDLE = 2'd0,
      CRF_SEND = 2'd1,
      CRF_FIN  = 2'd2
   } crf_state_e;

   typedef enum logic [1:0] {
      CRF_FN_NONE = 2'd0,
      CRF_FN_PAD  = 2'd1,
      CRF_FN_KBD  = 2'd2
   } crf_func_e;

   localparam int CRF_WORD_W      = 32;
   localparam int CRF_FRAME_WORDS = 4;

endpackage

// File: rtl/crf_cond_decode.sv
module crf_cond_decode #(
   parameter int WORD_W  = 32,
   parameter int PAD_BIT = 24,
   parameter int KBD_BIT = 30
) (
   input  logic [WORD_W-1:0]  cond_bus,
   output crf_pkg::crf_func_e func_sel,
   output logic [WORD_W-1:0]  func_bus
);
   import crf_pkg::*;

   localparam int LANES = WORD_W / 8;
   localparam logic [WORD_W-1:0] PAD_CODE = WORD_W'(1) << PAD_BIT;
   localparam logic [WORD_W-1:0] KBD_CODE = WORD_W'(1) << KBD_BIT;

   logic [WORD_W-1:0] mask;
   logic [WORD_W-1:0] pad_bus;
   logic [WORD_W-1:0] kbd_bus;

   // memory byte order: first byte read is the most significant mask byte
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mask[8*(LANES-1-g) +: 8]    = cond_bus[8*g +: 8];
      assign pad_bus[8*g +: 8]           = PAD_CODE[8*(LANES-1-g) +: 8];
      assign kbd_bus[8*g +: 8]           = KBD_CODE[8*(LANES-1-g) +: 8];
   end

   logic hit_pad;
   logic hit_kbd;
   assign hit_pad = |(mask & PAD_CODE);
   assign hit_kbd = |(mask & KBD_CODE);

   always_comb begin
      if (hit_pad) begin
         func_sel = CRF_FN_PAD;
         func_bus = pad_bus;
      end else if (hit_kbd) begin
         func_sel = CRF_FN_KBD;
         func_bus = kbd_bus;
      end else begin
         func_sel = CRF_FN_NONE;
         func_bus = '0;
      end
   end

endmodule

// File: rtl/crf_payload_pack.sv
module crf_payload_pack #(
   parameter int WORD_W = 32,
   parameter int BTN_W  = 16
) (
   input  logic               take,
   input  crf_pkg::crf_func_e func_sel,
   input  logic               pad_empty,
   input  logic [BTN_W-1:0]   pad_btn,
   input  logic               kbd_empty,
   input  logic [7:0]         kbd_mod,
   input  logic [7:0]         kbd_code,
   output logic               pad_pop,
   output logic               kbd_pop,
   output logic [WORD_W-1:0]  pay_lo,
   output logic [WORD_W-1:0]  pay_hi
);
   import crf_pkg::*;

   localparam int PAD_FILL = WORD_W - BTN_W;

   logic [BTN_W-1:0]  btn_now;
   logic [WORD_W-1:0] pad_word;
   logic [WORD_W-1:0] kbd_word;

   // an empty queue reads as no buttons pressed, then goes active low
   assign btn_now  = pad_empty ? '0 : pad_btn;
   assign pad_word = {{PAD_FILL{1'b0}}, ~btn_now};

   // byte 0 modifier, byte 1 led state (held 0), byte 2 scan code
   assign kbd_word = kbd_empty ? '0
                   : WORD_W'({8'h00, kbd_code, 8'h00, kbd_mod});

   assign pad_pop = take && (func_sel == CRF_FN_PAD) && !pad_empty;
   assign kbd_pop = take && (func_sel == CRF_FN_KBD) && !kbd_empty;

   always_comb begin
      unique case (func_sel)
         CRF_FN_PAD: pay_lo = pad_word;
         CRF_FN_KBD: pay_lo = kbd_word;
         default:    pay_lo = '0;
      endcase
   end

   // analogue axes and spare keyboard bytes are never driven
   assign pay_hi = '0;

endmodule

// File: rtl/crf_frame_seq.sv
module crf_frame_seq #(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 32,
   parameter int FRAME_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          take,
   input  logic                          take_none,
   input  logic [ADDR_W-1:0]             base_addr,
   input  logic [FRAME_WORDS*WORD_W-1:0] frame_in,
   input  logic                          wr_ready,
   output logic                          idle,
   output logic                          wr_valid,
   output logic [ADDR_W-1:0]             wr_addr,
   output logic [WORD_W-1:0]             wr_data,
   output logic                          done,
   output logic                          unsupported
);
   import crf_pkg::*;

   localparam int IDX_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
   localparam int STEP  = WORD_W / 8;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

   crf_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;
   logic              unsup_q;
   logic [WORD_W-1:0] frame_q [FRAME_WORDS];
   logic              load;

   assign load = (state_q == CRF_IDLE) && take && !take_none;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CRF_IDLE;
         idx_q   <= '0;
         base_q  <= '0;
         unsup_q <= 1'b0;
      end else begin
         unique case (state_q)
            CRF_IDLE: begin
               if (take) begin
                  unsup_q <= take_none;
                  idx_q   <= '0;
                  base_q  <= base_addr;
                  state_q <= take_none ? CRF_FIN : CRF_SEND;
               end
            end
            CRF_SEND: begin
               if (wr_ready) begin
                  if (idx_q == LAST_IDX) begin
                     state_q <= CRF_FIN;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            CRF_FIN: begin
               state_q <= CRF_IDLE;
            end
            default: state_q <= CRF_IDLE;
         endcase
      end
   end

   for (genvar w = 0; w < FRAME_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            frame_q[w] <= '0;
         end else if (load) begin
            frame_q[w] <= frame_in[w*WORD_W +: WORD_W];
         end
      end
   end

   assign idle        = (state_q == CRF_IDLE);
   assign wr_valid    = (state_q == CRF_SEND);
   assign wr_addr     = base_q + ADDR_W'(idx_q) * ADDR_W'(STEP);
   assign wr_data     = frame_q[idx_q];
   assign done        = (state_q == CRF_FIN);
   assign unsupported = (state_q == CRF_FIN) && unsup_q;

endmodule

// File: rtl/crf_writer.sv
module crf_writer #(
   parameter int          ADDR_W    = 32,
   parameter int          PORT_W    = 2,
   parameter int          BTN_W     = 16,
   parameter int          PAD_BIT   = 24,
   parameter int          KBD_BIT   = 30,
   parameter logic [7:0]  RESP_CODE = 8'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PORT_W-1:0] req_port,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_cond,
   input  logic              pad_empty,
   input  logic [BTN_W-1:0]  pad_btn,
   output logic              pad_pop,
   input  logic              kbd_empty,
   input  logic [7:0]        kbd_mod,
   input  logic [7:0]        kbd_code,
   output logic              kbd_pop,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   output logic              done,
   output logic              unsupported
);
   import crf_pkg::*;

   localparam int WORD_W      = CRF_WORD_W;
   localparam int FRAME_WORDS = CRF_FRAME_WORDS;
   localparam logic [7:0] LEN_WORDS = 8'(FRAME_WORDS - 1);

   if (PORT_W < 1 || PORT_W > 2) begin : g_bad_port
      $error("crf_writer: port number must fit in two bits");
   end
   if (BTN_W < 1 || BTN_W > 16) begin : g_bad_btn
      $error("crf_writer: button word must fit in payload bytes 0 and 1");
   end
   if (PAD_BIT == KBD_BIT || PAD_BIT >= WORD_W || KBD_BIT >= WORD_W) begin : g_bad_fn
      $error("crf_writer: function bits must be distinct and inside the mask");
   end

   crf_func_e         func_sel;
   logic [WORD_W-1:0] func_bus;
   logic [WORD_W-1:0] pay_lo;
   logic [WORD_W-1:0] pay_hi;
   logic [WORD_W-1:0] hdr_word;
   logic [7:0]        port_field;
   logic              take;
   logic              seq_idle;

   assign take       = req_valid && seq_idle;
   assign req_ready  = seq_idle;
   assign port_field = 8'(req_port) << 6;
   assign hdr_word   = {RESP_CODE, port_field | 8'h20, port_field, LEN_WORDS};

   crf_cond_decode #(
      .WORD_W  (WORD_W),
      .PAD_BIT (PAD_BIT),
      .KBD_BIT (KBD_BIT)
   ) u_decode (
      .cond_bus (req_cond),
      .func_sel (func_sel),
      .func_bus (func_bus)
   );

   crf_payload_pack #(
      .WORD_W (WORD_W),
      .BTN_W  (BTN_W)
   ) u_pack (
      .take      (take),
      .func_sel  (func_sel),
      .pad_empty (pad_empty),
      .pad_btn   (pad_btn),
      .kbd_empty (kbd_empty),
      .kbd_mod   (kbd_mod),
      .kbd_code  (kbd_code),
      .pad_pop   (pad_pop),
      .kbd_pop   (kbd_pop),
      .pay_lo    (pay_lo),
      .pay_hi    (pay_hi)
   );

   crf_frame_seq #(
      .ADDR_W      (ADDR_W),
      .WORD_W      (WORD_W),
      .FRAME_WORDS (FRAME_WORDS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (take),
      .take_none   (func_sel == CRF_FN_NONE),
      .base_addr   (req_addr),
      .frame_in    ({pay_hi, pay_lo, func_bus, hdr_word}),
      .wr_ready    (wr_ready),
      .idle        (seq_idle),
      .wr_valid    (wr_valid),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .done        (done),
      .unsupported (unsupported)
   );

endmodule

// File: rtl/crf_writer_chk.sv
module crf_writer_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              pad_empty,
   input logic              pad_pop,
   input logic              kbd_empty,
   input logic              kbd_pop,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_data,
   input logic              done,
   input logic              unsupported
);

   logic [2:0] hs_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_cnt <= '0;
      end else if (req_valid && req_ready) begin
         hs_cnt <= '0;
      end else if (wr_valid && wr_ready && hs_cnt != 3'd7) begin
         hs_cnt <= hs_cnt + 1'b1;
      end
   end

   AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid || done) |-> !req_ready);                                  // R1
   AST_HDR_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && hs_cnt == 3'd0) |-> (wr_data[7:0] == 8'd3));            // R2
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && hs_cnt < 3'd3) |=> (wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(4))); // R8
   AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pad_pop, kbd_pop}));                                       // R7
   AST_PAD_POP_OK: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pop |-> (req_valid && req_ready && !pad_empty));                 // R7
   AST_KBD_POP_OK: assert property (@(posedge clk) disable iff (!rst_n)
      kbd_pop |-> (req_valid && req_ready && !kbd_empty));                 // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                     // R9
   AST_FOUR_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !unsupported) |-> (hs_cnt == 3'd4));                        // R9
   AST_UNSUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && unsupported) |-> (hs_cnt == 3'd0));                         // R10
   AST_UNSUP_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> done);                                               // R10

endmodule

bind crf_writer crf_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .pad_empty   (pad_empty),
   .pad_pop     (pad_pop),
   .kbd_empty   (kbd_empty),
   .kbd_pop     (kbd_pop),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .done        (done),
   .unsupported (unsupported)
);

// File: tb/tb_crf_writer.sv
`timescale 1ns/100ps
module tb_crf_writer;

   localparam int WD_LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_port = '0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_cond = '0;
   logic        pad_empty = 1'b1;
   logic [15:0] pad_btn = '0;
   logic        pad_pop;
   logic        kbd_empty = 1'b1;
   logic [7:0]  kbd_mod = '0;
   logic [7:0]  kbd_code = '0;
   logic        kbd_pop;
   logic        wr_valid;
   logic        wr_ready = 1'b1;
   logic [31:0] wr_addr;
   logic [31:0] wr_data;
   logic        done;
   logic        unsupported;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ready_mode = 0;
   logic [7:0] lf = 8'h5a;
   bit seen_reset_check = 0;

   // reference model state
   int          m_st = 0;      // 0 idle, 1 sending, 2 finishing
   int          m_idx = 0;
   int          m_wcnt = 0;
   bit          m_unsup = 0;
   bit          m_pad = 0;
   bit          m_both = 0;
   logic [31:0] m_base = '0;
   logic [31:0] m_frame [4];

   always #2.5 clk = ~clk;

   crf_writer dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_port(req_port), .req_addr(req_addr), .req_cond(req_cond),
      .pad_empty(pad_empty), .pad_btn(pad_btn), .pad_pop(pad_pop),
      .kbd_empty(kbd_empty), .kbd_mod(kbd_mod), .kbd_code(kbd_code), .kbd_pop(kbd_pop),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(done), .unsupported(unsupported)
   );

   function automatic logic [31:0] swap32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // irregular acceptance from the memory side
   always @(negedge clk) begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      wr_ready <= (ready_mode == 0) ? 1'b1 : (lf[0] | lf[3]);
   end

   // per-cycle comparison against the behavioural reference
   always @(negedge clk) begin
      #1;
      if (!rst_n) begin
         if (!seen_reset_check) begin
            check(req_ready == 1'b1, "R11 req_ready", 32'(req_ready), 32'd1);
            check(wr_valid == 1'b0, "R11 wr_valid", 32'(wr_valid), 32'd0);
            check(done == 1'b0 && unsupported == 1'b0, "R11 done", {30'd0, done, unsupported}, 32'd0);
            seen_reset_check = 1;
         end
         m_st = 0; m_idx = 0; m_wcnt = 0; m_unsup = 0;
      end else begin
         logic [31:0] mask;
         bit sp, sk, acc;
         mask = swap32(req_cond);
         sp  = mask[24];
         sk  = !sp && mask[30];
         acc = (m_st == 0) && req_valid;

         check(req_ready == (m_st == 0), "R1 req_ready", 32'(req_ready), 32'(m_st == 0));
         check(pad_pop == (acc && sp && !pad_empty), "R7 pad_pop", 32'(pad_pop), 32'(acc && sp && !pad_empty));
         check(kbd_pop == (acc && sk && !kbd_empty), "R7 kbd_pop", 32'(kbd_pop), 32'(acc && sk && !kbd_empty));
         check(wr_valid == (m_st == 1), "R8 wr_valid", 32'(wr_valid), 32'(m_st == 1));
         check(done == (m_st == 2), "R9 done", 32'(done), 32'(m_st == 2));
         check(unsupported == (m_st == 2 && m_unsup), "R10 unsupported", 32'(unsupported), 32'(m_st == 2 && m_unsup));

         if (m_st == 1 && wr_valid) begin
            string tag;
            check(wr_addr == m_base + 32'(4 * m_idx), "R8 wr_addr", wr_addr, m_base + 32'(4 * m_idx));
            case (m_idx)
               0: tag = "R2 header";
               1: tag = m_both ? "R4 function" : "R3 function";
               default: tag = m_pad ? "R5 payload" : "R6 payload";
            endcase
            check(wr_data == m_frame[m_idx], tag, wr_data, m_frame[m_idx]);
         end
         if (m_st == 2) begin
            if (m_unsup) check(m_wcnt == 0, "R10 write count", 32'(m_wcnt), 32'd0);
            else         check(m_wcnt == 4, "R9 write count", 32'(m_wcnt), 32'd4);
         end

         // advance the model to the state after the coming edge
         case (m_st)
            0: if (acc) begin
               m_wcnt = 0;
               if (!sp && !sk) begin
                  m_st = 2; m_unsup = 1;
               end else begin
                  logic [7:0] pf;
                  pf = {req_port, 6'b0};
                  m_st = 1; m_idx = 0; m_unsup = 0; m_base = req_addr;
                  m_pad = sp; m_both = mask[24] && mask[30];
                  m_frame[0] = {8'h08, pf | 8'h20, pf, 8'h03};
                  m_frame[1] = sp ? swap32(32'h0100_0000) : swap32(32'h4000_0000);
                  if (sp) m_frame[2] = {16'h0000, ~(pad_empty ? 16'h0000 : pad_btn)};
                  else    m_frame[2] = kbd_empty ? 32'h0 : {8'h00, kbd_code, 8'h00, kbd_mod};
                  m_frame[3] = 32'h0;
               end
            end
            1: if (wr_ready) begin
               m_wcnt++;
               if (m_idx == 3) m_st = 2;
               else m_idx++;
            end
            default: m_st = 0;
         endcase
      end
   end

   task automatic query(input logic [1:0] port, input logic [31:0] addr, input logic [31:0] cond,
                        input bit pe, input logic [15:0] btn, input bit ke,
                        input logic [7:0] mod, input logic [7:0] code);
      @(negedge clk);
      req_port = port; req_addr = addr; req_cond = cond;
      pad_empty = pe; pad_btn = btn; kbd_empty = ke; kbd_mod = mod; kbd_code = code;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      pad_empty = 1'b1; kbd_empty = 1'b1;
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2 R3 R5: pad report, port 0, steady memory
      query(2'd0, 32'h0000_1000, 32'h0000_0001, 1'b0, 16'h0004, 1'b1, 8'h00, 8'h00);
      // R5: empty pad queue reports all released, port 1
      query(2'd1, 32'h0000_2040, 32'h0000_0001, 1'b1, 16'hABCD, 1'b1, 8'h00, 8'h00);
      ready_mode = 1;
      // R6: keyboard report with modifier, port 2, irregular memory
      query(2'd2, 32'h0001_0020, 32'h0000_0040, 1'b1, 16'h0000, 1'b0, 8'h02, 8'h04);
      // R6: empty keyboard queue, port 3
      query(2'd3, 32'h0002_0000, 32'h0000_0040, 1'b1, 16'h0000, 1'b1, 8'h11, 8'h22);
      // R4: both bits set, pad wins; keyboard queue left untouched
      query(2'd2, 32'h0000_3000, 32'h0000_0041, 1'b0, 16'h0F0F, 1'b0, 8'h01, 8'h2C);
      // R10: empty mask and a mask of unrelated bits
      query(2'd1, 32'h0000_4000, 32'h0000_0000, 1'b0, 16'h1234, 1'b0, 8'h01, 8'h05);
      query(2'd0, 32'h0000_4100, 32'h8000_0280, 1'b0, 16'h1234, 1'b0, 8'h01, 8'h05);
      // R1: request held valid across a busy frame, then released
      @(negedge clk);
      req_port = 2'd1; req_addr = 32'h0000_5000; req_cond = 32'h0000_0001;
      pad_empty = 1'b0; pad_btn = 16'h0780; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      check(req_ready == 1'b0, "R1 busy blocks", 32'(req_ready), 32'd0);
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      req_cond = 32'h0000_0040; kbd_empty = 1'b0; kbd_mod = 8'h00; kbd_code = 8'h1E;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0; pad_empty = 1'b1; kbd_empty = 1'b1;
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule